// File: doc/BRIEF.md
# Table-Driven Serial Clock Divider

This block derives a serial clock for an SPI shifter from a faster system clock. A 5-bit rate code selects a division ratio from a fixed ladder of values. The ladder alternates between a power of two and one and a half times a power of two: 3, 4, 6, 8, 12, 16, 24, 32 and so on, up to 1024. A code outside the legal window is pulled to the nearest legal code. The serial clock output goes with two one-cycle strobes. One marks the first cycle of each active phase, and the other marks the first cycle of each rest phase. The shifter next to this block uses them to launch and capture data.

A small state machine with three states produces the clock. `PH_IDLE` holds the clock at the polarity level. `PH_LEAD` drives the active level for floor(N/2) cycles. `PH_TRAIL` drives the rest level for ceil(N/2) cycles. The transitions are as follows. IDLE→LEAD happens on enable. LEAD→TRAIL happens when the lead count expires. TRAIL→LEAD happens when the trail count expires and enable is still high. LEAD→IDLE and TRAIL→IDLE happen when enable is sampled low. The ratio is captured only on entry to `PH_LEAD`, so a new code never cuts a period short. Two parameters set the variant. `MAX_CODE` is the highest legal code (16 or 18). `ALLOW_DIV3` makes code 1 (ratio 3) legal.

Top module: `sclk_ratio_gen`

## Requirements
- R1: A legal code c gives an SCLK period of ratio(c) clock cycles. For odd c, ratio(c) = 3·2^((c-1)/2). For even c, ratio(c) = 2^(c/2+1). Examples: 2→4, 5→12, 18→1024.
- R2: The active level (the inverse of `cpol`) lasts floor(N/2) cycles and the rest level lasts ceil(N/2) cycles. For N=3 this is 1 cycle active and 2 cycles at rest.
- R3: A code below the minimum acts as the minimum. With `ALLOW_DIV3`=0 the minimum is 2, which covers codes 0 and 1. With `ALLOW_DIV3`=1 the minimum is 1, which covers code 0.
- R4: A code above `MAX_CODE` acts as `MAX_CODE` (18 by default, 16 on the other variant).
- R5: While `en` is low, `sclk` equals `cpol` in the same cycle and both strobes are low. During reset, `sclk` equals `cpol`.
- R6: On the first rising clock edge at which `en` is seen high from idle, `sclk` goes to the active level and `lead_stb` is high for that first cycle.
- R7: `lead_stb` is high in exactly the first cycle of each active phase, and `trail_stb` in exactly the first cycle of each rest phase. The two are never high together.
- R8: The code is sampled at the edge that begins an active phase. A change made during a period takes effect at the next period.
- R9: With `ALLOW_DIV3`=1, code 1 gives ratio 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run the serial clock |
| rate_code | input | 5 | Index into the ratio ladder |
| cpol | input | 1 | Rest level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | First cycle of an active phase |
| trail_stb | output | 1 | First cycle of a rest phase |

## Verification
There is one register between a rising edge that samples `en` high and the active level with `lead_stb`. Both are therefore due right after that edge. The bench drives and samples 2 ns after each rising edge, so the first sample after enabling must already show the active phase. Dropping `en` takes effect in the same cycle, so the bench checks the rest level 1 ns after deasserting. Phase lengths are counted in those post-edge samples and compared with floor(N/2) and ceil(N/2) from a bench ratio function. A new code is written just after a lead sample, so the period in progress must keep the old ratio and the next period must use the new one.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_TRAIL = 2'd2
    } ph_state_e;

    // Ratio ladder: odd index -> 3*2^k, even index -> 2^k, index 0 unused.
    function automatic int unsigned ratio_of(input int unsigned idx);
        if (idx == 0)
            return 0;
        else if (idx[0])
            return 32'd3 << ((idx - 1) / 2);
        else
            return 32'd1 << (idx / 2 + 1);
    endfunction

endpackage

// File: rtl/sclk_ratio_lut.sv
module sclk_ratio_lut
    import sclk_div_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int MAX_CODE   = 18,
    parameter bit ALLOW_DIV3 = 1'b0,
    parameter int CNT_W      = 11
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  lead_len,
    output logic [CNT_W-1:0]  trail_len
);

    localparam int MIN_CODE = ALLOW_DIV3 ? 1 : 2;

    int unsigned eff_code;
    int unsigned ratio;

    always_comb begin
        if (int'(code) > MAX_CODE)
            eff_code = MAX_CODE;
        else if (int'(code) < MIN_CODE)
            eff_code = MIN_CODE;
        else
            eff_code = int'(code);
        ratio     = ratio_of(eff_code);
        lead_len  = CNT_W'(ratio / 2);
        trail_len = CNT_W'(ratio - ratio / 2);
    end

endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm
    import sclk_div_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cpol,
    input  logic [CNT_W-1:0] lead_len,
    input  logic [CNT_W-1:0] trail_len,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);

    ph_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] trail_q, trail_d;
    logic             first_q, first_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            trail_q <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            trail_q <= trail_d;
            first_q <= first_d;
        end
    end

    // Transitions; ratio is captured only when an active phase begins
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        trail_d = trail_q;
        first_d = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (en) begin
                    state_d = PH_LEAD;
                    cnt_d   = lead_len - 1'b1;
                    trail_d = trail_len;
                    first_d = 1'b1;
                end
            end
            PH_LEAD: begin
                if (!en) begin
                    state_d = PH_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = PH_TRAIL;
                    cnt_d   = trail_q - 1'b1;
                    first_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_TRAIL: begin
                if (!en) begin
                    state_d = PH_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = PH_LEAD;
                    cnt_d   = lead_len - 1'b1;
                    trail_d = trail_len;
                    first_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sclk      = cpol;
        lead_stb  = 1'b0;
        trail_stb = 1'b0;
        if (en) begin
            if (state_q == PH_LEAD) begin
                sclk     = ~cpol;
                lead_stb = first_q;
            end else if (state_q == PH_TRAIL) begin
                trail_stb = first_q;
            end
        end
    end

endmodule

// File: rtl/sclk_ratio_gen.sv
module sclk_ratio_gen
    import sclk_div_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int MAX_CODE   = 18,
    parameter bit ALLOW_DIV3 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              cpol,
    output logic              sclk,
    output logic              lead_stb,
    output logic              trail_stb
);

    localparam int CNT_W = $clog2(ratio_of(MAX_CODE) + 1);

    logic [CNT_W-1:0] lead_len;
    logic [CNT_W-1:0] trail_len;

    sclk_ratio_lut #(
        .CODE_W    (CODE_W),
        .MAX_CODE  (MAX_CODE),
        .ALLOW_DIV3(ALLOW_DIV3),
        .CNT_W     (CNT_W)
    ) u_lut (
        .code     (rate_code),
        .lead_len (lead_len),
        .trail_len(trail_len)
    );

    sclk_phase_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cpol     (cpol),
        .lead_len (lead_len),
        .trail_len(trail_len),
        .sclk     (sclk),
        .lead_stb (lead_stb),
        .trail_stb(trail_stb)
    );

endmodule

// File: rtl/sclk_ratio_gen_chk.sv
module sclk_ratio_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cpol,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb
);

    p_rest_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (sclk == cpol && !lead_stb && !trail_stb));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    p_lead_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != cpol));

    p_trail_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk == cpol));

    p_edge_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $stable(cpol) && (sclk != $past(sclk)))
            |-> (lead_stb || trail_stb));

    p_rest_min_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |=> !lead_stb);

endmodule

bind sclk_ratio_gen sclk_ratio_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cpol     (cpol),
    .sclk     (sclk),
    .lead_stb (lead_stb),
    .trail_stb(trail_stb)
);

// File: tb/sim_sclk_ratio_gen.sv
module sim_sclk_ratio_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en   [2];
    logic [4:0] code [2];
    logic       cpol [2];
    logic       sclk [2];
    logic       ls   [2];
    logic       ts   [2];

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    sclk_ratio_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en[0]), .rate_code(code[0]), .cpol(cpol[0]),
        .sclk(sclk[0]), .lead_stb(ls[0]), .trail_stb(ts[0])
    );

    sclk_ratio_gen #(.MAX_CODE(16), .ALLOW_DIV3(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .en(en[1]), .rate_code(code[1]), .cpol(cpol[1]),
        .sclk(sclk[1]), .lead_stb(ls[1]), .trail_stb(ts[1])
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp_code(input int s, input int c);
        int maxc = (s == 1) ? 16 : 18;
        int minc = (s == 1) ? 1 : 2;
        if (c > maxc) return maxc;
        if (c < minc) return minc;
        return c;
    endfunction

    function automatic int exp_ratio(input int s, input int c);
        int e = clamp_code(s, c);
        if (e % 2 == 1) return 3 << ((e - 1) / 2);
        return 1 << (e / 2 + 1);
    endfunction

    function automatic string tag_for(input int s, input int c);
        int maxc = (s == 1) ? 16 : 18;
        int minc = (s == 1) ? 1 : 2;
        if (c > maxc) return "R4";
        if (c < minc) return "R3";
        if (s == 1 && c == 1) return "R9";
        return "R1";
    endfunction

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // Two periods: first at code c1, code switched to c2 mid-period (R8)
    task automatic run_pattern(input int s, input int c1, input int c2, input bit pol);
        en[s]   = 1'b0;
        cpol[s] = pol;
        code[s] = 5'(c1);
        tick;
        tick;
        chk(sclk[s] == pol, "R5", "idle level", int'(sclk[s]), int'(pol));
        en[s] = 1'b1;
        tick;
        for (int p = 0; p < 2; p++) begin
            int    r   = (p == 0) ? exp_ratio(s, c1) : exp_ratio(s, c2);
            string tg  = (p == 0) ? tag_for(s, c1) : "R8";
            int    a   = 0;
            int    b   = 0;
            chk(ls[s] == 1'b1, (p == 0) ? "R6" : "R7", "lead strobe", int'(ls[s]), 1);
            if (p == 0) code[s] = 5'(c2);
            while (sclk[s] != pol && a < 2000) begin
                a++;
                tick;
            end
            chk(ts[s] == 1'b1, "R7", "trail strobe", int'(ts[s]), 1);
            while (sclk[s] == pol && !ls[s] && b < 2000) begin
                b++;
                tick;
            end
            chk(a + b == r, tg, "period", a + b, r);
            chk(a == r / 2 && b == r - r / 2, "R2", "active cycles", a, r / 2);
        end
        // now in first cycle of a third active phase; drop enable
        en[s] = 1'b0;
        #1;
        chk(sclk[s] == pol && !ls[s] && !ts[s], "R5", "rest on disable",
            int'(sclk[s]), int'(pol));
        tick;
        chk(sclk[s] == pol && !ls[s], "R5", "rest after disable",
            int'(sclk[s]), int'(pol));
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'd4711));
        rst_n   = 1'b0;
        en[0]   = 1'b0; en[1]   = 1'b0;
        code[0] = 5'd2; code[1] = 5'd2;
        cpol[0] = 1'b1; cpol[1] = 1'b0;
        repeat (3) tick;
        chk(sclk[0] == 1'b1 && !ls[0] && !ts[0], "R5", "reset level u0", int'(sclk[0]), 1);
        chk(sclk[1] == 1'b0 && !ls[1] && !ts[1], "R5", "reset level u1", int'(sclk[1]), 0);
        en[0] = 1'b1;
        #1;
        chk(sclk[0] == 1'b1, "R5", "enable in reset", int'(sclk[0]), 1);
        en[0] = 1'b0;
        rst_n = 1'b1;
        tick;

        // directed corners
        run_pattern(0, 2, 3, 1'b0);
        run_pattern(0, 0, 18, 1'b1);
        run_pattern(0, 31, 5, 1'b0);
        run_pattern(0, 1, 2, 1'b1);
        run_pattern(1, 1, 31, 1'b0);
        run_pattern(1, 0, 1, 1'b1);
        run_pattern(1, 17, 4, 1'b1);

        // constrained random
        for (int i = 0; i < 10; i++) begin
            for (int s = 0; s < 2; s++) begin
                int c1 = int'($urandom % 32);
                int c2 = int'($urandom % 32);
                run_pattern(s, c1, c2, 1'($urandom % 2));
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule